// File: doc/BRIEF.md
# Instruction TLB LRU and unified TLB random-counter replacement control

This block holds the replacement state of a translation unit that has a 4-entry instruction TLB and a 64-entry unified TLB. The state lives in one 32-bit MMU control register. The TLB arrays are kept elsewhere. The control register holds two fields that this block maintains:

- A 6-bit pairwise-order field (register bits 31:26). It records, for each pair of instruction TLB entries, which of the two was used more recently. The block decodes this field into the index of the least recently used entry, which is the entry to replace.
- A 6-bit replacement counter (bits 15:10). It advances on every unified TLB access. It wraps at a software-set boundary, held in bits 23:18, or at the top of its range.

Hardware reports an instruction TLB hit or refill through a use strobe with a 2-bit entry index. It reports unified TLB accesses through a second strobe. Software can load the whole register in one cycle. A software load overrides any hardware update in the same cycle. If the order field holds a pattern that names no entry, the block raises a sticky error and falls back to entry 0 as the victim until software reloads the register.

Top module: `itlb_repl_ctrl`

## Requirements
- R1: After reset the register reads 0, the error output is 0 and the victim index is 3.
- R2: Write L[k] for register bit 26+k. The victim decode takes the first match in this order: entry 0 when L[5], L[4] and L[3] are all 1; entry 1 when L[5]=0 and L[2]=L[1]=1; entry 2 when L[4]=0, L[2]=0 and L[0]=1; entry 3 when L[3], L[1] and L[0] are all 0.
- R3: A use strobe updates only the named L bits, one cycle after the strobe:
  - entry 0 clears L[5], L[4] and L[3];
  - entry 1 sets L[5] and clears L[2] and L[1];
  - entry 2 sets L[4] and L[2] and clears L[0];
  - entry 3 sets L[3], L[1] and L[0].
- R4: While the order field matches none of the patterns in R2, the error output is 1 and the victim is 0. The error stays 1 after the field becomes legal again, until a software load.
- R5: Each unified-access strobe adds 1 to the counter C in bits 15:10.
- R6: When the boundary B in bits 23:18 is nonzero and C+1 exceeds B, C becomes 0 instead.
- R7: When C+1 exceeds 63, C becomes 0, whatever the value of B.
- R8: A software load writes all 32 bits and clears the sticky error. It takes priority over use and access strobes in the same cycle.
- R9: Hardware updates leave bits 25:24, 17:16 and 9:0, and the boundary field, unchanged. Use and access strobes in the same cycle both take effect.
- R10: With no strobe and no load, the register holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_wr | input | 1 | Software load of the control register |
| sw_data | input | 32 | Value to load |
| itlb_use | input | 1 | Instruction TLB hit or refill |
| itlb_idx | input | 2 | Entry that was used |
| utlb_acc | input | 1 | Unified TLB access |
| mmucr | output | 32 | Current control register |
| victim_idx | output | 2 | Instruction TLB entry to replace |
| lru_err | output | 1 | Illegal order pattern seen since the last load |

## Verification
Assertions check the following on every cycle:
- The counter never exceeds a nonzero boundary after an access.
- A software load always wins over the strobes.
- Registers hold when idle.
- The error stays set until a load.
- A just-used instruction entry is never reported as the victim.

The exact bit updates for each entry, the decode priority, the wrap at 63, and the fallback victim while in error are shown by the bench, which compares the registers against a model on directed and random stimulus.

// File: rtl/itlb_repl_ctrl.sv
module itlb_repl_ctrl #(
  parameter int REG_W   = 32,
  parameter int ORD_LSB = 26,
  parameter int BND_LSB = 18,
  parameter int CNT_LSB = 10,
  parameter int CNT_W   = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_wr,
  input  logic [REG_W-1:0] sw_data,
  input  logic             itlb_use,
  input  logic [1:0]       itlb_idx,
  input  logic             utlb_acc,
  output logic [REG_W-1:0] mmucr,
  output logic [1:0]       victim_idx,
  output logic             lru_err
);
  localparam int ORD_W = 6;
  localparam int CNT_MAX = (1 << CNT_W) - 1;

  logic [REG_W-1:0] reg_q, reg_d;
  logic             err_q;
  logic [ORD_W-1:0] ord, ord_upd;
  logic [CNT_W-1:0] cnt, bnd, cnt_upd;
  logic [CNT_W:0]   cnt_inc;
  logic             m0, m1, m2, m3, bad;

  assign ord = reg_q[ORD_LSB +: ORD_W];
  assign cnt = reg_q[CNT_LSB +: CNT_W];
  assign bnd = reg_q[BND_LSB +: CNT_W];

  assign m0  = ord[5] & ord[4] & ord[3];
  assign m1  = ~ord[5] & ord[2] & ord[1];
  assign m2  = ~ord[4] & ~ord[2] & ord[0];
  assign m3  = ~ord[3] & ~ord[1] & ~ord[0];
  assign bad = ~(m0 | m1 | m2 | m3);

  assign lru_err = err_q | bad;
  assign victim_idx = lru_err ? 2'd0 : m0 ? 2'd0 : m1 ? 2'd1 : m2 ? 2'd2 : 2'd3;

  always_comb begin
    ord_upd = ord;
    case (itlb_idx)
      2'd0: ord_upd[5:3] = 3'b000;
      2'd1: begin ord_upd[5] = 1'b1; ord_upd[2:1] = 2'b00; end
      2'd2: begin ord_upd[4] = 1'b1; ord_upd[2] = 1'b1; ord_upd[0] = 1'b0; end
      default: begin ord_upd[3] = 1'b1; ord_upd[1:0] = 2'b11; end
    endcase
  end

  assign cnt_inc = {1'b0, cnt} + 1'b1;
  assign cnt_upd = (((bnd != '0) && (cnt_inc > {1'b0, bnd})) || (cnt_inc > CNT_MAX))
                   ? '0 : cnt_inc[CNT_W-1:0];

  always_comb begin
    reg_d = reg_q;
    if (itlb_use) reg_d[ORD_LSB +: ORD_W] = ord_upd;
    if (utlb_acc) reg_d[CNT_LSB +: CNT_W] = cnt_upd;
    if (sw_wr)    reg_d = sw_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_q <= '0;
      err_q <= 1'b0;
    end else begin
      reg_q <= reg_d;
      err_q <= sw_wr ? 1'b0 : (err_q | bad);
    end
  end

  assign mmucr = reg_q;

  // R6
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (utlb_acc && !sw_wr && bnd != '0) |=> (mmucr[CNT_LSB +: CNT_W] <= $past(bnd)));

  // R8
  sw_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_wr |=> (mmucr == $past(sw_data)));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_wr && !itlb_use && !utlb_acc) |=> $stable(mmucr));

  // R4
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lru_err && !sw_wr) |=> lru_err);

  // R3
  used_not_victim_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (itlb_use && !sw_wr) |=> (lru_err || victim_idx != $past(itlb_idx)));

  // R9
  other_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_wr |=> ($stable(mmucr[25:24]) && $stable(mmucr[23:16]) && $stable(mmucr[9:0])));
endmodule

// File: tb/itlb_repl_ctrl_tb_top.sv
module itlb_repl_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sw_wr = 1'b0;
  logic [31:0] sw_data = '0;
  logic        itlb_use = 1'b0;
  logic [1:0]  itlb_idx = '0;
  logic        utlb_acc = 1'b0;
  logic [31:0] mmucr;
  logic [1:0]  victim_idx;
  logic        lru_err;

  int checks = 0;
  int errors = 0;
  logic [31:0] m_reg = '0;
  logic        m_err = 1'b0;

  itlb_repl_ctrl dut_i (.clk(clk), .rst_n(rst_n), .sw_wr(sw_wr), .sw_data(sw_data),
    .itlb_use(itlb_use), .itlb_idx(itlb_idx), .utlb_acc(utlb_acc),
    .mmucr(mmucr), .victim_idx(victim_idx), .lru_err(lru_err));

  always #5 clk = ~clk;

  function automatic logic f_bad(input logic [5:0] o);
    return !((o[5] & o[4] & o[3]) | (!o[5] & o[2] & o[1]) |
             (!o[4] & !o[2] & o[0]) | (!o[3] & !o[1] & !o[0]));
  endfunction

  function automatic logic [1:0] f_victim(input logic [5:0] o, input logic e);
    if (e || f_bad(o)) return 2'd0;
    if (o[5] & o[4] & o[3]) return 2'd0;
    if (!o[5] & o[2] & o[1]) return 2'd1;
    if (!o[4] & !o[2] & o[0]) return 2'd2;
    return 2'd3;
  endfunction

  function automatic logic [31:0] f_next(input logic [31:0] r, input logic w, input logic [31:0] d,
                                         input logic u, input logic [1:0] i, input logic a);
    logic [31:0] n = r;
    int c, b;
    if (u) begin
      case (i)
        2'd0: n[31:29] = 3'b000;
        2'd1: begin n[31] = 1'b1; n[28:27] = 2'b00; end
        2'd2: begin n[30] = 1'b1; n[28] = 1'b1; n[26] = 1'b0; end
        default: begin n[29] = 1'b1; n[27:26] = 2'b11; end
      endcase
    end
    if (a) begin
      c = int'(r[15:10]) + 1;
      b = int'(r[23:18]);
      if ((b != 0 && c > b) || c > 63) c = 0;
      n[15:10] = c[5:0];
    end
    if (w) n = d;
    return n;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    check({tag, " reg"}, mmucr, m_reg);
    check({tag, " err"}, {31'd0, lru_err}, {31'd0, m_err | f_bad(m_reg[31:26])});
    check({tag, " victim"}, {30'd0, victim_idx}, {30'd0, f_victim(m_reg[31:26], m_err)});
  endtask

  task automatic step(input logic w, input logic [31:0] d, input logic u,
                      input logic [1:0] i, input logic a);
    @(negedge clk);
    sw_wr = w; sw_data = d; itlb_use = u; itlb_idx = i; utlb_acc = a;
    @(posedge clk);
    #1;
    m_err = w ? 1'b0 : (m_err | f_bad(m_reg[31:26]));
    m_reg = f_next(m_reg, w, d, u, i, a);
    @(negedge clk);
    sw_wr = 1'b0; itlb_use = 1'b0; utlb_acc = 1'b0;
  endtask

  initial begin
    #1500000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset reg", mmucr, 32'h0);
    check("R1 reset victim", {30'd0, victim_idx}, 32'd3);
    check("R1 reset err", {31'd0, lru_err}, 32'd0);

    // R2 decode of each entry
    step(1, {6'b111000, 26'h0}, 0, 0, 0); check_all("R2 entry0");
    step(1, {6'b000110, 26'h0}, 0, 0, 0); check_all("R2 entry1");
    step(1, {6'b000001, 26'h0}, 0, 0, 0); check_all("R2 entry2");
    step(1, {6'b111111, 26'h0}, 0, 0, 0); check_all("R2 priority entry0");
    // R3 use of each entry
    step(1, 32'h0, 0, 0, 0);
    for (int k = 0; k < 4; k++) begin
      step(0, 0, 1, 2'(k), 0); check_all("R3 use update");
    end
    // R4 illegal pattern, sticky, then cleared by load
    step(1, {6'b101010, 26'h0}, 0, 0, 0); check_all("R4 illegal");
    check("R4 err raised", {31'd0, lru_err}, 32'd1);
    step(0, 0, 1, 2'd0, 0); check_all("R4 sticky");
    check("R4 victim fallback", {30'd0, victim_idx}, 32'd0);
    step(1, 32'h0, 0, 0, 0); check_all("R8 clears err");
    check("R8 err cleared", {31'd0, lru_err}, 32'd0);
    // R5 R6 R7 counter
    step(1, {8'h0, 6'd5, 2'b0, 6'd4, 10'h0}, 0, 0, 0);
    step(0, 0, 0, 0, 1); check_all("R5 increment");
    check("R5 cnt", {26'd0, mmucr[15:10]}, 32'd5);
    step(0, 0, 0, 0, 1); check("R6 wrap at bound", {26'd0, mmucr[15:10]}, 32'd0);
    step(1, {8'h0, 6'd5, 2'b0, 6'd7, 10'h0}, 0, 0, 0);
    step(0, 0, 0, 0, 1); check("R6 wrap above bound", {26'd0, mmucr[15:10]}, 32'd0);
    step(1, {8'h0, 6'd0, 2'b0, 6'd63, 10'h3ff}, 0, 0, 0);
    step(0, 0, 0, 0, 1); check("R7 wrap at top", {26'd0, mmucr[15:10]}, 32'd0);
    check_all("R9 other bits");
    // R8 priority and R9 simultaneous
    step(1, 32'hdead_beef, 1, 2'd3, 1); check_all("R8 priority");
    step(1, 32'h0300_0000, 0, 0, 0);
    step(0, 0, 1, 2'd2, 1); check_all("R9 both strobes");
    step(0, 0, 0, 0, 0); check_all("R10 idle hold");

    // random mix covering R2 R3 R4 R5 R6 R7 R8 R9 R10
    for (int n = 0; n < 3000; n++) begin
      logic w;
      logic [31:0] d;
      w = ($urandom % 16) == 0;
      d = $urandom;
      if ($urandom % 2) d[31:26] = 6'b000000;
      if ($urandom % 3) d[23:18] = 6'($urandom % 8);
      step(w, d, 1'($urandom), 2'($urandom), 1'($urandom));
      check_all("R2 R3 R4 R5 R6 R7 R8 R9 R10 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule